// File: doc/BRIEF.md
# Ternary Packet Header Classifier

This block is a small ternary match table that sorts IPv4 flows by their 5-tuple. Each entry stores a 104-bit compare pattern, a 104-bit care mask and a valid bit. Software or a control engine loads the entries through a single-cycle write port. Per-field masks express address prefixes, wildcarded ports and exact protocol codes.

On every cycle the datapath can present one extracted header key with a strobe. The key is compared against all valid entries at once. One clock later the block reports whether any entry matched and the index of the lowest-numbered matching entry. Parsing, counters and match actions belong to other blocks.

Top module: `tpc_classifier`

## Requirements
- R1: After the active-low asynchronous reset, `hit_o` is 0, `hit_idx_o` is 0, and every entry is invalid, so no key produces a hit until an entry is written.
- R2: The key is packed from the most significant bit downward: source IPv4 address in [103:72], destination IPv4 address in [71:40], source port in [39:24], destination port in [23:8] and protocol code in [7:0]. A mismatch in any cared-for field prevents a match.
- R3: For each key bit, a mask bit of 1 requires that bit to equal the stored value bit, and a mask bit of 0 makes that bit don't-care. A prefix of length N sets the top N mask bits of its address field. A fully wildcarded field has its whole mask cleared.
- R4: An entry whose valid bit is 0 never matches, whatever its value and mask hold.
- R5: When several valid entries match, `hit_idx_o` reports the lowest index among them.
- R6: `hit_o` and `hit_idx_o` are registered. They reflect the key presented with `key_valid_i`=1 at the previous rising edge. `hit_o` is 0 in the cycle after an edge at which `key_valid_i` was 0.
- R7: A write sampled at a rising edge affects lookups sampled from the next edge onward. A lookup sampled at the same edge as the write sees the old entry contents.
- R8: `hit_idx_o` is 0 whenever `hit_o` is 0.
- R9: Writing an entry that is already in use replaces its value, mask and valid bit completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one entry |
| wr_idx_i | input | 3 | Entry index being written |
| wr_value_i | input | 104 | Compare pattern for the entry |
| wr_mask_i | input | 104 | Care mask for the entry (1 = compare) |
| wr_valid_i | input | 1 | Valid bit stored with the entry |
| key_valid_i | input | 1 | Key strobe |
| key_i | input | 104 | Packed 5-tuple search key |
| hit_o | output | 1 | Registered match flag |
| hit_idx_o | output | 3 | Registered index of lowest matching entry |

## Verification
A corrupted value, mask or valid bit in a stored entry appears at the ports on the first lookup that touches that entry. The lookup returns a wrong hit, a missing hit or a wrong index one clock after the key strobe. A priority fault only shows when two entries overlap, so the stimulus programs overlapping prefixes and a catch-all entry. Write-to-lookup ordering is exposed by issuing a write and a lookup at the same edge and then repeating the lookup.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int unsigned SRC_IP_W = 32;
  localparam int unsigned DST_IP_W = 32;
  localparam int unsigned PORT_W   = 16;
  localparam int unsigned PROTO_W  = 8;
  localparam int unsigned KEY_W    = SRC_IP_W + DST_IP_W + 2 * PORT_W + PROTO_W;

  // field order is fixed: source address at the MSB end, protocol at the LSB end
  typedef struct packed {
    logic [SRC_IP_W-1:0] src_ip;
    logic [DST_IP_W-1:0] dst_ip;
    logic [PORT_W-1:0]   src_port;
    logic [PORT_W-1:0]   dst_port;
    logic [PROTO_W-1:0]  proto;
  } tuple_t;

  typedef struct packed {
    logic        vld;
    logic [KEY_W-1:0] value;
    logic [KEY_W-1:0] mask;
  } rule_t;
endpackage

// File: rtl/tpc_entry.sv
module tpc_entry
  import tpc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_sel_i,
  input  logic [KEY_W-1:0] wr_value_i,
  input  logic [KEY_W-1:0] wr_mask_i,
  input  logic             wr_valid_i,
  input  tuple_t           key_i,
  output logic             match_o
);
  rule_t rule_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rule_q <= '0;
    end else if (wr_sel_i) begin
      rule_q.vld   <= wr_valid_i;
      rule_q.value <= wr_value_i;
      rule_q.mask  <= wr_mask_i;
    end
  end

  logic [KEY_W-1:0] diff;
  assign diff    = (KEY_W'(key_i) ^ rule_q.value) & rule_q.mask;
  assign match_o = rule_q.vld && (diff == '0);

  // R4
  invalid_write_no_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_sel_i && !wr_valid_i) |-> !match_o);

  // R7
  write_takes_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_sel_i && wr_valid_i && ((KEY_W'(key_i) ^ wr_value_i) & wr_mask_i) == '0)
      && $stable(key_i) |-> match_o);
endmodule

// File: rtl/tpc_prio.sv
module tpc_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;

  // R5
  always_comb begin
    if (any_o) begin
      lowest_req_chk: assert (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/tpc_classifier.sv
module tpc_classifier
  import tpc_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [KEY_W-1:0] wr_value_i,
  input  logic [KEY_W-1:0] wr_mask_i,
  input  logic             wr_valid_i,
  input  logic             key_valid_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o
);
  tuple_t               key_t;
  logic [NUM_ENTRIES-1:0] match;
  logic                 any_match;
  logic [IDX_W-1:0]     win_idx;

  assign key_t = tuple_t'(key_i);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    tpc_entry u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_sel_i   (wr_en_i && (wr_idx_i == IDX_W'(e))),
      .wr_value_i (wr_value_i),
      .wr_mask_i  (wr_mask_i),
      .wr_valid_i (wr_valid_i),
      .key_i      (key_t),
      .match_o    (match[e])
    );
  end

  tpc_prio #(.N(NUM_ENTRIES)) u_prio (
    .req_i (match),
    .any_o (any_match),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
    end else begin
      hit_o     <= key_valid_i && any_match;
      hit_idx_o <= (key_valid_i && any_match) ? win_idx : '0;
    end
  end

  // R6
  hit_needs_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(key_valid_i));

  // R8
  idle_idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_idx_o == '0));
endmodule

// File: tb/tb_tpc_classifier.sv
module tb_tpc_classifier;
  import tpc_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_idx = '0;
  logic [KEY_W-1:0] wr_value = '0;
  logic [KEY_W-1:0] wr_mask = '0;
  logic             wr_valid = 1'b0;
  logic             key_valid = 1'b0;
  logic [KEY_W-1:0] key = '0;
  logic             hit;
  logic [2:0]       hit_idx;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tpc_classifier dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_value_i(wr_value), .wr_mask_i(wr_mask), .wr_valid_i(wr_valid),
    .key_valid_i(key_valid), .key_i(key), .hit_o(hit), .hit_idx_o(hit_idx)
  );

  localparam int NV = 8;
  localparam logic [KEY_W-1:0] VEC_KEY [NV] = '{
    {32'h80FC1234, 32'hC0A83207, 16'h1111, 16'd80, 8'd6},
    {32'h80FC1234, 32'hC0A83207, 16'h1111, 16'd80, 8'd17},
    {32'h80FD0000, 32'hC0A83207, 16'h1111, 16'd80, 8'd6},
    {32'h80FC1234, 32'hC0A83307, 16'h1111, 16'd80, 8'd6},
    {32'h0A010203, 32'h01020304, 16'h5000, 16'd53, 8'd17},
    {32'h0A010203, 32'h01020304, 16'h5000, 16'd54, 8'd17},
    {32'h0B000000, 32'h01020304, 16'h5000, 16'd53, 8'd6},
    {32'h80FC0000, 32'hC0A832FF, 16'hFFFF, 16'd80, 8'd6}
  };
  localparam logic       VEC_HIT [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [2:0] VEC_IDX [NV] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd2, 3'd3, 3'd0, 3'd0};

  task automatic check(string req, logic exp_hit, logic [2:0] exp_idx);
    checks++;
    if (hit !== exp_hit || hit_idx !== exp_idx) begin
      errors++;
      $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", req, hit, hit_idx, exp_hit, exp_idx);
    end
  endtask

  task automatic write_entry(logic [2:0] idx, logic [KEY_W-1:0] v, logic [KEY_W-1:0] m, logic vld);
    wr_en = 1'b1; wr_idx = idx; wr_value = v; wr_mask = m; wr_valid = vld;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(logic [KEY_W-1:0] k);
    key_valid = 1'b1; key = k;
    @(posedge clk); @(negedge clk);
    key_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while held in reset
    check("R1 in reset", 1'b0, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0, 3'd0);
    lookup('0);
    check("R1 empty table", 1'b0, 3'd0);

    // R3: 128.252/16 -> 192.168.50/24, any source port, dport 80, TCP
    write_entry(3'd0, {32'h80FC0000, 32'hC0A83200, 16'h0, 16'd80, 8'd6},
                      {32'hFFFF0000, 32'hFFFFFF00, 16'h0, 16'hFFFF, 8'hFF}, 1'b1);
    write_entry(3'd2, {64'h0, 16'h0, 16'd53, 8'd17},
                      {64'h0, 16'h0, 16'hFFFF, 8'hFF}, 1'b1);
    write_entry(3'd3, {32'h0A000000, 72'h0}, {32'hFF000000, 72'h0}, 1'b1);

    // R2 R3 R5 R8: vector walk
    for (int i = 0; i < NV; i++) begin
      lookup(VEC_KEY[i]);
      check($sformatf("R2/R3/R5 vector %0d", i), VEC_HIT[i], VEC_IDX[i]);
    end

    // R6: no strobe, no hit even with a matching key
    key = VEC_KEY[0]; key_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6 strobe low", 1'b0, 3'd0);

    // R7: write catch-all to entry 1 at the same edge as a lookup
    wr_en = 1'b1; wr_idx = 3'd1; wr_value = '0; wr_mask = '0; wr_valid = 1'b1;
    key_valid = 1'b1; key = VEC_KEY[1];
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; key_valid = 1'b0;
    check("R7 same edge sees old", 1'b0, 3'd0);
    lookup(VEC_KEY[1]);
    check("R7 next lookup sees new", 1'b1, 3'd1);

    // R5: entry 0 beats catch-all entry 1
    lookup(VEC_KEY[0]);
    check("R5 lowest wins", 1'b1, 3'd0);

    // R4: invalidate entry 0, its pattern no longer matches
    write_entry(3'd0, {32'h80FC0000, 32'hC0A83200, 16'h0, 16'd80, 8'd6},
                      {32'hFFFF0000, 32'hFFFFFF00, 16'h0, 16'hFFFF, 8'hFF}, 1'b0);
    lookup(VEC_KEY[0]);
    check("R4 invalid entry skipped", 1'b1, 3'd1);

    // R4: invalid all-wildcard entry at index 0 still never matches
    write_entry(3'd0, '0, '0, 1'b0);
    lookup(VEC_KEY[6]);
    check("R4 invalid wildcard", 1'b1, 3'd1);

    // R9: overwrite entry 1 with an exact-match rule
    write_entry(3'd1, VEC_KEY[7], '1, 1'b1);
    lookup(VEC_KEY[6]);
    check("R9 old rule gone", 1'b0, 3'd0);
    lookup(VEC_KEY[7]);
    check("R9 new rule", 1'b1, 3'd1);

    // R3: single-bit change in a cared bit
    lookup(VEC_KEY[7] ^ {{(KEY_W-1){1'b0}}, 1'b1});
    check("R3 lsb mismatch", 1'b0, 3'd0);

    // R1: asynchronous reset clears results and table
    @(posedge clk); #2; rst_n = 1'b0; #2;
    check("R1 async clear", 1'b0, 3'd0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    lookup(VEC_KEY[4]);
    check("R1 table cleared", 1'b0, 3'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule